// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a processor-style bus and an on-chip flash array. Software talks to the flash only through bus write cycles whose low data byte carries a command code. The sequencer decodes these codes, gathers the two-cycle sequences for program and erase, and launches each operation on the array through a one-cycle request pulse. The array answers later with a one-cycle done pulse and a fail flag.

Reads from the bus return either array contents or the status register, depending on the current read mode. Starting any program or erase operation switches reads to status mode. Status mode lasts until software writes the read-array code, or until the flash reset input is raised. While an operation runs, the block drops its ready output. It ignores every command write until the array reports completion.

Top module: `fseq_top`

## Requirements
- R1: After synchronous reset the ready output is 1, the status byte is 80h, no request is pending, and reads return array data.
- R2: Only bus_wdata[7:0] is decoded as a command; the upper byte never changes the decode. Codes other than FFh, 70h, 50h, 40h and 20h written while idle have no effect, and that includes D0h.
- R3: Code FFh selects array reads; code 70h selects status reads and lasts until FFh is written. A read strobe loads bus_rdata at the next clock edge, either with the array word at bus_addr or with {8'h00, status}. The status byte is laid out as bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 sequence error, and all other bits 0.
- R4: Code 50h clears the three error bits and leaves the ready bit as it is.
- R5: Program is 40h written at any address, followed by a write whose address has bit 0 = 0. That second write issues arr_req with arr_op = 1, arr_addr equal to the second write address, and arr_wdata equal to the full 16-bit data.
- R6: Block erase is 20h followed by D0h written at the highest word address of a block: address bit 0 = 0 and address bits [BLK_SHIFT-1:1] all ones. It issues arr_op = 2, with arr_addr equal to the block base (low BLK_SHIFT bits cleared).
- R7: Erase-all is 20h followed by a second 20h at any address. It issues arr_op = 3 with arr_addr = 0.
- R8: A second-cycle write that breaks the sequence sets the sequence-error bit, issues no request and returns the sequencer to idle. Breaking writes are a wrong code after 20h, a D0h at an address that is not a block top, or a program data write with address bit 0 = 1.
- R9: arr_req pulses for exactly one cycle. Ready falls in the same cycle that arr_req rises, and rises one edge after arr_done is sampled high.
- R10: Launching any operation switches reads to status mode, and status mode remains after completion.
- R11: While ready is 0, command writes of any code have no effect, and reads return status.
- R12: arr_done with arr_fail = 1 sets the program-error bit after a program, and sets the erase-error bit after either kind of erase.
- R13: flash_rst high at a clock edge aborts any partial sequence or running operation, sets ready, and selects array reads. An arr_done arriving afterwards changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flash_rst | input | 1 | Software flash reset bit |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Read data, loaded one edge after bus_rd |
| ready | output | 1 | 1 = idle, 0 = operation running |
| status | output | 8 | Status register byte |
| arr_req | output | 1 | One-cycle operation request to the array |
| arr_op | output | 2 | Operation: 1 program, 2 block erase, 3 erase all |
| arr_addr | output | ADDR_W | Operation address |
| arr_wdata | output | DATA_W | Program data |
| arr_raddr | output | ADDR_W | Array read address (follows bus_addr) |
| arr_rdata | input | DATA_W | Array read data for arr_raddr |
| arr_done | input | 1 | One-cycle completion pulse |
| arr_fail | input | 1 | Failure flag, valid with arr_done |

## Verification
Every effect of a write is due one clock edge after the edge that samples bus_wr: the read mode, the status bits, arr_req and the fall of ready. Read data is due one edge after the read strobe is sampled. Ready returns one edge after arr_done is sampled. The bench drives stimulus on the falling edge and samples on the falling edge that follows the relevant rising edge. When arr_done is seen, it checks that ready is still 0, and one falling edge later it checks that ready is 1.

// File: rtl/fseq_pkg.sv
// Shared types and command codes for the flash command sequencer.
// Assumes byte addressing with 16-bit words (address bit 0 selects a byte).
package fseq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PGM2 = 2'd1,
        S_ERS2 = 2'd2,
        S_BUSY = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_BLK  = 2'd2,
        OP_ALL  = 2'd3
    } arr_op_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_RDARR,
        K_RDSTAT,
        K_CLR,
        K_PROG,
        K_ERASE,
        K_CONF
    } cmd_kind_t;

    localparam logic [7:0] CODE_RDARR  = 8'hFF;
    localparam logic [7:0] CODE_RDSTAT = 8'h70;
    localparam logic [7:0] CODE_CLR    = 8'h50;
    localparam logic [7:0] CODE_PROG   = 8'h40;
    localparam logic [7:0] CODE_ERASE  = 8'h20;
    localparam logic [7:0] CODE_CONF   = 8'hD0;

    localparam int SB_READY = 7;
    localparam int SB_EERR  = 5;
    localparam int SB_PERR  = 4;
    localparam int SB_SERR  = 3;

endpackage

// File: rtl/fseq_decode.sv
// Command decoder: classifies the low data byte and qualifies the address.
// Purely combinational. Assumes BLK_SHIFT >= 2 and BLK_SHIFT < ADDR_W.
module fseq_decode
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 12
) (
    input  logic [7:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output cmd_kind_t         kind,
    output logic              aligned,
    output logic              blk_top,
    output logic [ADDR_W-1:0] blk_base
);

    localparam int HI_W = ADDR_W - BLK_SHIFT;

    // Map the command byte onto a command kind.
    always_comb begin
        unique case (code)
            CODE_RDARR:  kind = K_RDARR;
            CODE_RDSTAT: kind = K_RDSTAT;
            CODE_CLR:    kind = K_CLR;
            CODE_PROG:   kind = K_PROG;
            CODE_ERASE:  kind = K_ERASE;
            CODE_CONF:   kind = K_CONF;
            default:     kind = K_NONE;
        endcase
    end

    // Word alignment, block-top detection and block base address.
    always_comb begin
        aligned  = ~addr[0];
        blk_top  = &addr[BLK_SHIFT-1:1];
        blk_base = {addr[ADDR_W-1:BLK_SHIFT], {BLK_SHIFT{1'b0}}};
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr[ADDR_W-1:BLK_SHIFT];

endmodule

// File: rtl/fseq_ctrl.sv
// Sequencer state machine: gathers two-cycle sequences, launches array
// operations, tracks ready/busy, read mode and the error bits.
// Assumes bus_wr is a one-cycle strobe per write and arr_done a one-cycle pulse.
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  cmd_kind_t         kind,
    input  logic              aligned,
    input  logic              blk_top,
    input  logic [ADDR_W-1:0] blk_base,
    input  logic              arr_done,
    input  logic              arr_fail,
    output logic              ready,
    output logic              mode_stat,
    output logic              err_erase,
    output logic              err_prog,
    output logic              err_seq,
    output logic              arr_req,
    output logic [1:0]        arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    seq_state_t        state;
    arr_op_t           cur_op;
    logic              launch;
    logic              seq_bad;
    arr_op_t           launch_op;
    logic [ADDR_W-1:0] launch_addr;
    logic [DATA_W-1:0] launch_data;

    // Decide whether this write completes a sequence or breaks it.
    always_comb begin
        launch      = 1'b0;
        seq_bad     = 1'b0;
        launch_op   = OP_NONE;
        launch_addr = bus_addr;
        launch_data = '0;
        if (bus_wr && !flash_rst) begin
            unique case (state)
                S_PGM2: begin
                    if (aligned) begin
                        launch      = 1'b1;
                        launch_op   = OP_PROG;
                        launch_data = bus_wdata;
                    end else begin
                        seq_bad = 1'b1;
                    end
                end
                S_ERS2: begin
                    if (kind == K_CONF && aligned && blk_top) begin
                        launch      = 1'b1;
                        launch_op   = OP_BLK;
                        launch_addr = blk_base;
                    end else if (kind == K_ERASE) begin
                        launch      = 1'b1;
                        launch_op   = OP_ALL;
                        launch_addr = '0;
                    end else begin
                        seq_bad = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state, status bits and the request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_op    <= OP_NONE;
            ready     <= 1'b1;
            mode_stat <= 1'b0;
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_seq   <= 1'b0;
            arr_req   <= 1'b0;
            arr_addr  <= '0;
            arr_wdata <= '0;
        end else begin
            arr_req <= 1'b0;
            if (flash_rst) begin
                state     <= S_IDLE;
                ready     <= 1'b1;
                mode_stat <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (bus_wr) begin
                            unique case (kind)
                                K_RDARR:  mode_stat <= 1'b0;
                                K_RDSTAT: mode_stat <= 1'b1;
                                K_CLR: begin
                                    err_erase <= 1'b0;
                                    err_prog  <= 1'b0;
                                    err_seq   <= 1'b0;
                                end
                                K_PROG:   state <= S_PGM2;
                                K_ERASE:  state <= S_ERS2;
                                default:  ;
                            endcase
                        end
                    end
                    S_PGM2, S_ERS2: begin
                        if (seq_bad) begin
                            err_seq <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                    S_BUSY: begin
                        if (arr_done) begin
                            ready <= 1'b1;
                            state <= S_IDLE;
                            if (arr_fail) begin
                                if (cur_op == OP_PROG) err_prog <= 1'b1;
                                else                   err_erase <= 1'b1;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
                if (launch) begin
                    state     <= S_BUSY;
                    ready     <= 1'b0;
                    mode_stat <= 1'b1;
                    arr_req   <= 1'b1;
                    cur_op    <= launch_op;
                    arr_addr  <= launch_addr;
                    arr_wdata <= launch_data;
                end
            end
        end
    end

    assign arr_op = cur_op;

endmodule

// File: rtl/fseq_rdport.sv
// Registered read port: on a read strobe, captures status or array data.
// Assumes the array answers arr_rdata combinationally for the current address.
module fseq_rdport #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              show_stat,
    input  logic [7:0]        status,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - 8;

    // Load the selected source when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= show_stat ? {{PAD_W{1'b0}}, status} : arr_rdata;
        end
    end

endmodule

// File: rtl/fseq_top.sv
// Flash command sequencer top: decoder, sequencer and read port.
// Assumes a single clock domain, synchronous active-low reset, DATA_W >= 8.
module fseq_top
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BLK_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ready,
    output logic [7:0]        status,
    output logic              arr_req,
    output logic [1:0]        arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              arr_done,
    input  logic              arr_fail
);

    cmd_kind_t         kind;
    logic              aligned;
    logic              blk_top;
    logic [ADDR_W-1:0] blk_base;
    logic              mode_stat;
    logic              err_erase;
    logic              err_prog;
    logic              err_seq;

    fseq_decode #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_dec (
        .code     (bus_wdata[7:0]),
        .addr     (bus_addr),
        .kind     (kind),
        .aligned  (aligned),
        .blk_top  (blk_top),
        .blk_base (blk_base)
    );

    fseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flash_rst (flash_rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .kind      (kind),
        .aligned   (aligned),
        .blk_top   (blk_top),
        .blk_base  (blk_base),
        .arr_done  (arr_done),
        .arr_fail  (arr_fail),
        .ready     (ready),
        .mode_stat (mode_stat),
        .err_erase (err_erase),
        .err_prog  (err_prog),
        .err_seq   (err_seq),
        .arr_req   (arr_req),
        .arr_op    (arr_op),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

    // Assemble the status byte from the sequencer flags.
    always_comb begin
        status           = '0;
        status[SB_READY] = ready;
        status[SB_EERR]  = err_erase;
        status[SB_PERR]  = err_prog;
        status[SB_SERR]  = err_seq;
    end

    assign arr_raddr = bus_addr;

    fseq_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .show_stat (mode_stat | ~ready),
        .status    (status),
        .arr_rdata (arr_rdata),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/fseq_checker.sv
// Protocol checker for fseq_top, attached by bind.
// Assumes the top-level signal names of fseq_top.
module fseq_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flash_rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              ready,
    input logic [7:0]        status,
    input logic              arr_req,
    input logic              arr_done,
    input logic              mode_stat,
    input logic [DATA_W-1:0] bus_rdata
);

    // R9
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !ready);

    // R9
    ready_fall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> arr_req);

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req);

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_done && !ready && !flash_rst) |=> ready);

    // R10
    req_status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> mode_stat);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ready && !flash_rst && !arr_done) |=> $stable(status));

    // R13
    flash_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rst |=> (ready && !mode_stat && !arr_req));

    // R3
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && mode_stat) |=> (bus_rdata == {{(DATA_W-8){1'b0}}, $past(status)}));

endmodule

bind fseq_top fseq_checker #(.DATA_W(DATA_W)) u_fseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flash_rst (flash_rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .ready     (ready),
    .status    (status),
    .arr_req   (arr_req),
    .arr_done  (arr_done),
    .mode_stat (mode_stat),
    .bus_rdata (bus_rdata)
);

// File: tb/fseq_top_test.sv
// Self-checking bench for fseq_top: directed corners plus seeded random traffic.
module fseq_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ready;
    logic [7:0]  status;
    logic        arr_req;
    logic [1:0]  arr_op;
    logic [15:0] arr_addr;
    logic [15:0] arr_wdata;
    logic [15:0] arr_raddr;
    logic [15:0] arr_rdata;
    logic        arr_done = 1'b0;
    logic        arr_fail = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 3;
    int cnt = 0;
    bit fail_next = 1'b0;

    bit exp_ready = 1'b1;
    bit exp_mode  = 1'b0;
    bit exp_e = 1'b0, exp_p = 1'b0, exp_s = 1'b0;

    always #2 clk = ~clk;

    fseq_top uut (
        .clk(clk), .rst_n(rst_n), .flash_rst(flash_rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready),
        .status(status), .arr_req(arr_req), .arr_op(arr_op),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_raddr(arr_raddr),
        .arr_rdata(arr_rdata), .arr_done(arr_done), .arr_fail(arr_fail)
    );

    function automatic logic [15:0] arr_val(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    assign arr_rdata = arr_val(arr_raddr);

    function automatic logic [7:0] exp_status();
        return {exp_ready, 1'b0, exp_e, exp_p, exp_s, 3'b000};
    endfunction

    // Behavioural array: done pulse lat cycles after a request.
    always @(posedge clk) begin
        arr_done <= 1'b0;
        if (arr_req) begin
            cnt <= lat;
        end else if (cnt > 1) begin
            cnt <= cnt - 1;
        end else if (cnt == 1) begin
            cnt      <= 0;
            arr_done <= 1'b1;
            arr_fail <= fail_next;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input string tag);
        logic [15:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e = (exp_mode || !exp_ready) ? {8'h00, exp_status()} : arr_val(a);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic stat_chk(input string tag);
        chk(status == exp_status(), tag, status, exp_status());
    endtask

    // Called at the falling edge right after the launching write.
    task automatic launch_chk(input string tag, input logic [1:0] op,
                              input logic [15:0] a, input logic [15:0] d);
        chk(arr_req == 1'b1, tag, arr_req, 1);
        chk(ready == 1'b0, "R9 ready low with request", ready, 0);
        chk({arr_op, arr_addr, arr_wdata} == {op, a, d}, tag,
            {arr_op, arr_addr, arr_wdata}, {op, a, d});
        exp_ready = 1'b0;
        exp_mode  = 1'b1;
    endtask

    task automatic wait_done(input bit was_prog);
        int n = 0;
        while (!arr_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(ready == 1'b0, "R9 ready still low when done seen", ready, 0);
        @(negedge clk);
        chk(ready == 1'b1, "R9 ready one edge after done", ready, 1);
        exp_ready = 1'b1;
        if (fail_next) begin
            if (was_prog) exp_p = 1'b1;
            else          exp_e = 1'b1;
        end
        stat_chk("R12 status after completion");
    endtask

    task automatic no_req_chk(input string tag);
        chk(arr_req == 1'b0, tag, arr_req, 0);
        stat_chk(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(status == 8'h80, "R1 status after reset", status, 8'h80);
        chk(arr_req == 1'b0, "R1 no request after reset", arr_req, 0);
        rd_chk(16'h0124, "R1 array read after reset");

        // R2 / R3 high byte ignored, mode selection
        wr(16'h0000, 16'hAB70); exp_mode = 1'b1;
        rd_chk(16'h0200, "R2 R3 status mode with high byte set");
        rd_chk(16'h0300, "R3 status mode persists");
        wr(16'h0000, 16'h0033);
        rd_chk(16'h0300, "R2 unknown code ignored");
        wr(16'h0000, 16'h00D0);
        no_req_chk("R2 D0h idle ignored");
        wr(16'h0000, 16'h12FF); exp_mode = 1'b0;
        rd_chk(16'h0456, "R2 R3 array mode with high byte set");

        // R8 sequence errors, R4 clear
        wr(16'h0000, 16'h0020); wr(16'h0010, 16'h0055);
        exp_s = 1'b1; no_req_chk("R8 wrong confirm code");
        wr(16'h0000, 16'h0050); exp_s = 1'b0; stat_chk("R4 clear errors");
        wr(16'h0000, 16'h0020); wr(16'h1F00, 16'h00D0);
        exp_s = 1'b1; no_req_chk("R8 D0h not at block top");
        wr(16'h0000, 16'h0020); wr(16'h1FFF, 16'h00D0);
        no_req_chk("R8 D0h with odd address");
        wr(16'h0000, 16'h0040); wr(16'h0101, 16'hBEEF);
        no_req_chk("R8 program odd address");
        rd_chk(16'h0040, "R8 sequencer idle after error");

        // R5 program, R10 status mode, R12 fail
        lat = 4; fail_next = 1'b1;
        wr(16'h0000, 16'h0040); wr(16'h0100, 16'hBEEF);
        launch_chk("R5 program request", 2'd1, 16'h0100, 16'hBEEF);
        wait_done(1'b1);
        rd_chk(16'h0100, "R10 status mode after program");

        // R6 block erase at block top, base address
        fail_next = 1'b0;
        wr(16'h0000, 16'h0020); wr(16'h3FFE, 16'hFFD0);
        launch_chk("R6 block erase request", 2'd2, 16'h3000, 16'h0000);
        wait_done(1'b0);

        // R7 erase all, fail sets erase error
        fail_next = 1'b1;
        wr(16'h0000, 16'h0020); wr(16'h5555, 16'h0020);
        launch_chk("R7 erase-all request", 2'd3, 16'h0000, 16'h0000);
        wait_done(1'b0);
        wr(16'h0000, 16'h0050); exp_e = 1'b0; exp_p = 1'b0; exp_s = 1'b0;
        stat_chk("R4 clear keeps ready");

        // R11 commands ignored while busy
        lat = 20; fail_next = 1'b0;
        wr(16'h0000, 16'h0020); wr(16'h0000, 16'h0055); exp_s = 1'b1;
        wr(16'h0000, 16'h0040); wr(16'h0200, 16'h1234);
        launch_chk("R5 program request", 2'd1, 16'h0200, 16'h1234);
        wr(16'h0000, 16'h0050); stat_chk("R11 clear ignored while busy");
        wr(16'h0000, 16'h00FF);
        rd_chk(16'h0008, "R11 read gives status while busy");
        wr(16'h0000, 16'h0040); no_req_chk("R11 program ignored while busy");
        wait_done(1'b1);
        wr(16'h0202, 16'h0012); no_req_chk("R11 no pending sequence after busy");

        // R13 flash reset during operation and during a sequence
        fail_next = 1'b1;
        wr(16'h0000, 16'h0020); wr(16'h0000, 16'h0020);
        launch_chk("R7 erase-all request", 2'd3, 16'h0000, 16'h0000);
        @(negedge clk); flash_rst = 1'b1;
        @(negedge clk); flash_rst = 1'b0;
        exp_ready = 1'b1; exp_mode = 1'b0;
        chk(ready == 1'b1, "R13 ready after flash reset", ready, 1);
        rd_chk(16'h0444, "R13 array mode after flash reset");
        repeat (25) @(negedge clk);
        stat_chk("R13 late done ignored");
        wr(16'h0000, 16'h0040);
        @(negedge clk); flash_rst = 1'b1;
        @(negedge clk); flash_rst = 1'b0;
        wr(16'h0010, 16'h0034);
        no_req_chk("R13 sequence aborted by flash reset");

        // Random traffic
        for (int i = 0; i < 150; i++) begin
            int k;
            logic [15:0] a;
            logic [7:0]  c;
            k = int'($urandom % 8);
            a = 16'($urandom);
            lat = 2 + int'($urandom % 5);
            fail_next = ($urandom % 4) == 0;
            case (k)
                0: begin wr(a, {8'($urandom), 8'hFF}); exp_mode = 1'b0; stat_chk("R3 random read array"); end
                1: begin wr(a, {8'($urandom), 8'h70}); exp_mode = 1'b1; stat_chk("R3 random read status"); end
                2: begin wr(a, 16'h0050); exp_e = 0; exp_p = 0; exp_s = 0; stat_chk("R4 random clear"); end
                3: begin
                    wr(16'h0000, 16'h0040);
                    if ($urandom % 2) a[0] = 1'b0;
                    wr(a, bus_wdata ^ 16'hC3A5);
                    if (a[0]) begin exp_s = 1'b1; no_req_chk("R8 random odd program"); end
                    else begin launch_chk("R5 random program", 2'd1, a, arr_wdata); wait_done(1'b1); end
                end
                4: begin
                    wr(16'h0000, 16'h0020);
                    if ($urandom % 2) a = {a[15:12], 12'hFFE};
                    wr(a, 16'h00D0);
                    if (a[0] == 1'b0 && a[11:1] == 11'h7FF) begin
                        launch_chk("R6 random block erase", 2'd2, {a[15:12], 12'h000}, 16'h0000);
                        wait_done(1'b0);
                    end else begin
                        exp_s = 1'b1; no_req_chk("R8 random bad block address");
                    end
                end
                5: begin
                    wr(16'h0000, 16'h0020); wr(a, 16'h0020);
                    launch_chk("R7 random erase all", 2'd3, 16'h0000, 16'h0000);
                    wait_done(1'b0);
                end
                6: begin
                    c = 8'($urandom);
                    while (c == 8'hFF || c == 8'h70 || c == 8'h50 || c == 8'h40 || c == 8'h20)
                        c = 8'($urandom);
                    wr(a, {8'($urandom), c});
                    no_req_chk("R2 random unknown code");
                end
                default: rd_chk(a, "R3 random read");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule